// File: doc/BRIEF.md
# Memory-Mapped Flash Read Front End

This block sits between a simple memory-mapped read port and a flash transaction sequencer. A bus read that is not already covered by the buffer becomes one burst request to the sequencer. The request carries the flash address, the number of words to fetch, and the command and dummy settings in force for streamed reads. The block then collects the returned words into a small burst buffer. The requested word goes back to the bus as soon as it arrives, and later reads that fall inside the fetched range are answered from the buffer without another flash access.

The flash address is formed from the bus address by a 12-bit mask. Bit i of the mask clears address bit 16+i, which sets how large the flash device appears. Bursts normally fetch a parameter-set number of words. An optional programmable word limit can shorten them. A sticky completion flag records the end of each burst until software clears it.

Top module: `xip_rd_front`

## Requirements
- R1: The flash address is the bus address with bit 16+i forced to zero wherever mask bit i is 1. All other bits pass unchanged, except bits 1:0, which are zero. For example, mask values 0xFE0, 0xFC0, 0xF00 and 0xE00 keep 21, 22, 24 and 25 low address bits respectively.
- R2: After reset, bus_ready, seq_req and done_flag are all low.
- R3: A read that misses the buffer while streaming is on raises seq_req, which stays high until seq_ack. seq_req carries the word-aligned flash address of the requested word as the burst start. It also carries cfg_cmd and cfg_dummy as they were when the read was taken, and seq_addr holds stable until the request is accepted.
- R4: The burst length seq_words is BURST_WORDS (8 by default). When cfg_lim_en is 1, the length is the smaller of BURST_WORDS and cfg_lim+1.
- R5: When streaming is on and the masked word address lies in [start, start+words) of the last completed burst, the read is answered in the cycle after it is seen, with no new flash request. A read one word past the range is a miss.
- R6: bus_size encodes 0 as byte, 1 as halfword and 2 or 3 as word. A byte read returns the lane selected by addr[1:0], and a halfword read returns the half selected by addr[1]. Each selected lane keeps its bit position in bus_rdata, and all other bits are zero.
- R7: bus_ready stays low from the request until the data is ready, and is a one-cycle pulse. On a miss it rises one cycle after the first word of the burst arrives.
- R8: Streaming is on only while cfg_pf_en and cfg_rd_en are both 1. Otherwise a read is answered in the next cycle with zero data, no flash request is made, and the buffered words are discarded.
- R9: done_flag is set when a burst ends (seq_done) and is cleared by a one-cycle done_clr. A set in the same cycle as a clear takes priority.
- R10: A read presented while a burst is still being received waits until that burst has ended, and is then served from the refreshed buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Read request, held until bus_ready |
| bus_addr | input | 32 | Byte address of the read |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| bus_ready | output | 1 | One-cycle pulse: read data valid |
| bus_rdata | output | 32 | Read data, lane-aligned |
| cfg_pf_en | input | 1 | Streamed-read mode enable |
| cfg_rd_en | input | 1 | Read enable for streamed mode |
| cfg_mask | input | 12 | Address-bit removal mask for bits 27:16 |
| cfg_lim_en | input | 1 | Enables the burst word limit |
| cfg_lim | input | 8 | Word limit minus one |
| cfg_cmd | input | 8 | Command code for streamed reads |
| cfg_dummy | input | 5 | Dummy cycle count for streamed reads |
| seq_req | output | 1 | Burst request to the sequencer |
| seq_addr | output | 32 | Burst start flash address |
| seq_words | output | 4 | Words in the burst |
| seq_cmd | output | 8 | Command code captured for this burst |
| seq_dummy | output | 5 | Dummy count captured for this burst |
| seq_ack | input | 1 | Sequencer accepts the request |
| seq_rvalid | input | 1 | A returned word is valid |
| seq_rdata | input | 32 | Returned word |
| seq_done | input | 1 | Burst has ended |
| done_flag | output | 1 | Sticky burst-completion status |
| done_clr | input | 1 | Write-one-to-clear pulse for done_flag |

## Verification
The assertions assume three things about the surroundings:

- The mask, limit and enable inputs stay stable while a burst is outstanding.
- The sequencer returns no more words than seq_words, with at least one word before seq_done.
- The bus master holds its address and size until bus_ready.

The stimulus keeps to these rules. The bench changes configuration only between reads, after any burst has fully ended. Its sequencer model returns exactly the requested count and then pulses seq_done once.

// File: rtl/xrf_pkg.sv
package xrf_pkg;

   typedef enum logic [1:0] {
      XS_BYTE = 2'd0,
      XS_HALF = 2'd1,
      XS_WORD = 2'd2
   } xfer_size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_FILL  = 2'd2
   } fe_state_e;

endpackage

// File: rtl/xrf_addr_mask.sv
module xrf_addr_mask #(
   parameter int ADDR_W    = 32,
   parameter int MASK_LSB  = 16,
   parameter int MASK_BITS = 12
) (
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [MASK_BITS-1:0] mask_i,
   output logic [ADDR_W-1:0]    addr_o
);

   if (MASK_LSB + MASK_BITS > ADDR_W) begin : g_bad_span
      $error("mask span exceeds address width");
   end

   for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
      if (b >= MASK_LSB && b < MASK_LSB + MASK_BITS) begin : g_gated
         assign addr_o[b] = addr_i[b] & ~mask_i[b-MASK_LSB];
      end else begin : g_pass
         assign addr_o[b] = addr_i[b];
      end
   end

endmodule

// File: rtl/xrf_lane_pick.sv
module xrf_lane_pick
   import xrf_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] word_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic [1:0]        size_i,
   output logic [DATA_W-1:0] word_o
);

   if (DATA_W % 8 != 0 || LANES < 4) begin : g_bad_width
      $error("data width must be a whole number of bytes, at least 4");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic keep;
      always_comb begin
         case (size_i)
            XS_BYTE: keep = (ofs_i == OFS_W'(l));
            XS_HALF: keep = ((ofs_i >> 1) == OFS_W'(l / 2));
            default: keep = 1'b1;
         endcase
      end
      assign word_o[8*l +: 8] = keep ? word_i[8*l +: 8] : 8'h00;
   end

endmodule

// File: rtl/xrf_word_buf.sv
module xrf_word_buf #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   parameter int WA_W   = 30,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              load_i,
   input  logic [WA_W-1:0]   base_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              commit_i,
   input  logic [WA_W-1:0]   look_i,
   output logic              hit_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("buffer depth must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [WA_W-1:0]   base_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              vld_q;
   logic              wr_ok;
   logic [WA_W-1:0]   diff;

   assign wr_ok = wr_i && (cnt_q < DEPTH_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         vld_q  <= 1'b0;
      end else begin
         if (load_i) begin
            base_q <= base_i;
            cnt_q  <= '0;
         end else if (wr_ok) begin
            cnt_q  <= cnt_q + 1'b1;
         end
         if (clr_i || load_i)
            vld_q <= 1'b0;
         else if (commit_i)
            vld_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok)
         mem[cnt_q[IDX_W-1:0]] <= wdata_i;
   end

   assign diff    = look_i - base_q;
   assign hit_o   = vld_q && (diff < WA_W'(cnt_q));
   assign rdata_o = mem[diff[IDX_W-1:0]];

   // R4
   no_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |-> cnt_q < DEPTH_C);

endmodule

// File: rtl/xip_rd_front.sv
module xip_rd_front
   import xrf_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int MASK_LSB    = 16,
   parameter int MASK_BITS   = 12,
   parameter int BURST_WORDS = 8,
   parameter int LIM_W       = 8,
   parameter int CMD_W       = 8,
   parameter int DUMMY_W     = 5,
   localparam int CNT_W      = $clog2(BURST_WORDS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_req,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [1:0]           bus_size,
   output logic                 bus_ready,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic                 cfg_pf_en,
   input  logic                 cfg_rd_en,
   input  logic [MASK_BITS-1:0] cfg_mask,
   input  logic                 cfg_lim_en,
   input  logic [LIM_W-1:0]     cfg_lim,
   input  logic [CMD_W-1:0]     cfg_cmd,
   input  logic [DUMMY_W-1:0]   cfg_dummy,
   output logic                 seq_req,
   output logic [ADDR_W-1:0]    seq_addr,
   output logic [CNT_W-1:0]     seq_words,
   output logic [CMD_W-1:0]     seq_cmd,
   output logic [DUMMY_W-1:0]   seq_dummy,
   input  logic                 seq_ack,
   input  logic                 seq_rvalid,
   input  logic [DATA_W-1:0]    seq_rdata,
   input  logic                 seq_done,
   output logic                 done_flag,
   input  logic                 done_clr
);

   localparam int OFS_W = $clog2(DATA_W / 8);
   localparam int WA_W  = ADDR_W - OFS_W;
   localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST_WORDS);
   localparam logic [LIM_W:0]   BURST_L = (LIM_W + 1)'(BURST_WORDS);

   if (BURST_WORDS > (1 << LIM_W)) begin : g_bad_limit
      $error("burst length exceeds the range of the word limit");
   end
   if (MASK_LSB < OFS_W) begin : g_bad_lsb
      $error("mask must not reach the byte offset bits");
   end

   fe_state_e         state;
   logic              en;
   logic              accept;
   logic              start_miss;
   logic              buf_hit;
   logic [ADDR_W-1:0] bus_ma;
   logic [WA_W-1:0]   bus_wa;
   logic [LIM_W:0]    lim_p1;
   logic [CNT_W-1:0]  eff_words;
   logic [DATA_W-1:0] buf_word;
   logic [DATA_W-1:0] pick_in;
   logic [DATA_W-1:0] pick_out;
   logic [OFS_W-1:0]  pick_ofs;
   logic [1:0]        pick_size;
   logic [OFS_W-1:0]  req_ofs;
   logic [1:0]        req_size;
   logic              got_first;

   assign en = cfg_pf_en & cfg_rd_en;

   xrf_addr_mask #(
      .ADDR_W   (ADDR_W),
      .MASK_LSB (MASK_LSB),
      .MASK_BITS(MASK_BITS)
   ) u_mask (
      .addr_i(bus_addr),
      .mask_i(cfg_mask),
      .addr_o(bus_ma)
   );

   assign bus_wa = bus_ma[ADDR_W-1:OFS_W];

   assign lim_p1    = {1'b0, cfg_lim} + 1'b1;
   assign eff_words = (cfg_lim_en && lim_p1 < BURST_L) ? lim_p1[CNT_W-1:0] : BURST_C;

   assign accept     = (state == ST_IDLE) && bus_req && !bus_ready;
   assign start_miss = accept && en && !buf_hit;

   xrf_word_buf #(
      .DATA_W(DATA_W),
      .DEPTH (BURST_WORDS),
      .WA_W  (WA_W)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (!en),
      .load_i  (start_miss),
      .base_i  (bus_wa),
      .wr_i    ((state == ST_FILL) && seq_rvalid),
      .wdata_i (seq_rdata),
      .commit_i((state == ST_FILL) && seq_done),
      .look_i  (bus_wa),
      .hit_o   (buf_hit),
      .rdata_o (buf_word)
   );

   assign pick_in   = (state == ST_FILL) ? seq_rdata : buf_word;
   assign pick_ofs  = (state == ST_FILL) ? req_ofs   : bus_addr[OFS_W-1:0];
   assign pick_size = (state == ST_FILL) ? req_size  : bus_size;

   xrf_lane_pick #(.DATA_W(DATA_W)) u_pick (
      .word_i(pick_in),
      .ofs_i (pick_ofs),
      .size_i(pick_size),
      .word_o(pick_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         seq_req   <= 1'b0;
         seq_addr  <= '0;
         seq_words <= '0;
         seq_cmd   <= '0;
         seq_dummy <= '0;
         bus_ready <= 1'b0;
         bus_rdata <= '0;
         req_ofs   <= '0;
         req_size  <= '0;
         got_first <= 1'b0;
      end else begin
         bus_ready <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (!en) begin
                     bus_ready <= 1'b1;
                     bus_rdata <= '0;
                  end else if (buf_hit) begin
                     bus_ready <= 1'b1;
                     bus_rdata <= pick_out;
                  end else begin
                     state     <= ST_ISSUE;
                     seq_req   <= 1'b1;
                     seq_addr  <= {bus_wa, {OFS_W{1'b0}}};
                     seq_words <= eff_words;
                     seq_cmd   <= cfg_cmd;
                     seq_dummy <= cfg_dummy;
                     req_ofs   <= bus_addr[OFS_W-1:0];
                     req_size  <= bus_size;
                     got_first <= 1'b0;
                  end
               end
            end
            ST_ISSUE: begin
               if (seq_ack) begin
                  seq_req <= 1'b0;
                  state   <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (seq_rvalid && !got_first) begin
                  bus_ready <= 1'b1;
                  bus_rdata <= pick_out;
                  got_first <= 1'b1;
               end
               if (seq_done)
                  state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         done_flag <= 1'b0;
      else if ((state == ST_FILL) && seq_done)
         done_flag <= 1'b1;
      else if (done_clr)
         done_flag <= 1'b0;
   end

   // R7
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready);

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_req && !seq_ack |=> seq_req && $stable(seq_addr) && $stable(seq_words));

   // R1
   mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_req |-> ((seq_addr[MASK_LSB +: MASK_BITS] & cfg_mask) == '0)
                  && (seq_addr[OFS_W-1:0] == '0));

   // R4
   burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_req |-> (seq_words != '0) && (seq_words <= BURST_C)
                  && (!cfg_lim_en || (LIM_W + 1)'(seq_words) <= lim_p1));

   // R8
   off_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_req) |-> $past(cfg_pf_en && cfg_rd_en));

   // R9
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL) && seq_done |=> done_flag);

   // R10
   fill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL) && got_first && !seq_done |=> !bus_ready);

endmodule

// File: tb/sim_xip_rd_front.sv
`timescale 1ns/1ps
module sim_xip_rd_front;

   localparam int BW = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_req;
   logic [31:0] bus_addr;
   logic [1:0]  bus_size;
   logic        bus_ready;
   logic [31:0] bus_rdata;
   logic        cfg_pf_en, cfg_rd_en, cfg_lim_en;
   logic [11:0] cfg_mask;
   logic [7:0]  cfg_lim, cfg_cmd;
   logic [4:0]  cfg_dummy;
   logic        seq_req;
   logic [31:0] seq_addr;
   logic [3:0]  seq_words;
   logic [7:0]  seq_cmd;
   logic [4:0]  seq_dummy;
   logic        seq_ack, seq_rvalid, seq_done;
   logic [31:0] seq_rdata;
   logic        done_flag, done_clr;

   always #2.5 clk = ~clk;

   xip_rd_front u0 (
      .clk(clk), .rst_n(rst_n),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata),
      .cfg_pf_en(cfg_pf_en), .cfg_rd_en(cfg_rd_en), .cfg_mask(cfg_mask),
      .cfg_lim_en(cfg_lim_en), .cfg_lim(cfg_lim), .cfg_cmd(cfg_cmd),
      .cfg_dummy(cfg_dummy),
      .seq_req(seq_req), .seq_addr(seq_addr), .seq_words(seq_words),
      .seq_cmd(seq_cmd), .seq_dummy(seq_dummy), .seq_ack(seq_ack),
      .seq_rvalid(seq_rvalid), .seq_rdata(seq_rdata), .seq_done(seq_done),
      .done_flag(done_flag), .done_clr(done_clr)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int n_issue = 0;
   int last_cyc = 0;
   bit seq_busy = 1'b0;

   // reference model state
   bit          m_valid = 1'b0;
   logic [29:0] m_base = '0;
   int          m_cnt = 0;
   logic [31:0] exp_addr;
   int          exp_words;
   logic [7:0]  exp_cmd;
   logic [4:0]  exp_dummy;

   function automatic logic [31:0] fw(input logic [29:0] wa);
      return ({2'b00, wa} * 32'h9E37_79B1) ^ 32'h5A5A_1234;
   endfunction

   function automatic logic [31:0] mask_a(input logic [31:0] a, input logic [11:0] m);
      logic [31:0] r = a;
      for (int i = 0; i < 12; i++) if (m[i]) r[16+i] = 1'b0;
      return r;
   endfunction

   function automatic logic [31:0] lanes(input logic [31:0] w, input logic [1:0] o,
                                         input logic [1:0] s);
      logic [31:0] r = '0;
      if (s == 2'd0)      r[8*o +: 8] = w[8*o +: 8];
      else if (s == 2'd1) r[16*o[1] +: 16] = w[16*o[1] +: 16];
      else                r = w;
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // sequencer model, compared on every request it sees
   initial begin
      seq_ack = 0; seq_rvalid = 0; seq_done = 0; seq_rdata = '0;
      forever begin
         @(negedge clk);
         if (seq_req) begin
            logic [31:0] ca;
            int          cw;
            seq_busy = 1'b1;
            n_issue++;
            ca = seq_addr;
            cw = int'(seq_words);
            chk("R3 burst start address", seq_addr, exp_addr);
            chk("R4 burst word count", 32'(seq_words), 32'(exp_words));
            chk("R3 command code", 32'(seq_cmd), 32'(exp_cmd));
            chk("R3 dummy count", 32'(seq_dummy), 32'(exp_dummy));
            seq_ack = 1'b1;
            @(negedge clk);
            seq_ack = 1'b0;
            for (int k = 0; k < cw; k++) begin
               seq_rvalid = 1'b1;
               seq_rdata  = fw(ca[31:2] + 30'(k));
               @(negedge clk);
               seq_rvalid = 1'b0;
               if (k % 2 == 1) @(negedge clk);
            end
            seq_done = 1'b1;
            @(negedge clk);
            seq_done = 1'b0;
            seq_busy = 1'b0;
         end
      end
   end

   task automatic rd(input logic [31:0] a, input logic [1:0] s, input string tag,
                     input bit settle, input bit chk_lat);
      logic [31:0] ma;
      logic [29:0] wa;
      logic [31:0] exp_d;
      bit          en, miss;
      int          i0, cyc, eff;
      ma = mask_a(a, cfg_mask);
      wa = ma[31:2];
      en = cfg_pf_en && cfg_rd_en;
      miss = 1'b0;
      if (!en) begin
         m_valid = 1'b0;
         exp_d = '0;
      end else begin
         exp_d = lanes(fw(wa), a[1:0], s);
         if (!(m_valid && int'(wa - m_base) < m_cnt && (wa - m_base) < 30'd64)) begin
            miss = 1'b1;
            eff = cfg_lim_en ? ((int'(cfg_lim) + 1 < BW) ? int'(cfg_lim) + 1 : BW) : BW;
            m_base = wa; m_cnt = eff; m_valid = 1'b1;
            exp_addr = {wa, 2'b00}; exp_words = eff;
            exp_cmd = cfg_cmd; exp_dummy = cfg_dummy;
         end
      end
      i0 = n_issue;
      bus_addr = a; bus_size = s; bus_req = 1'b1;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!bus_ready && cyc < 300);
      bus_req = 1'b0;
      last_cyc = cyc;
      chk({tag, " data"}, bus_rdata, exp_d);
      chk({tag, " flash requests"}, 32'(n_issue - i0), 32'(miss));
      if (chk_lat) chk({tag, " R7 latency"}, 32'(cyc), miss ? 32'd3 : 32'd1);
      @(negedge clk);
      chk("R7 ready is a single pulse", 32'(bus_ready), 32'd0);
      if (settle) begin
         while (seq_busy) @(negedge clk);
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst_n = 0; bus_req = 0; bus_addr = '0; bus_size = 2'd2;
      cfg_pf_en = 1; cfg_rd_en = 1; cfg_mask = 12'hFFF;
      cfg_lim_en = 0; cfg_lim = '0; cfg_cmd = 8'hEB; cfg_dummy = 5'd6;
      done_clr = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R2 reset bus_ready", 32'(bus_ready), 32'd0);
      chk("R2 reset seq_req", 32'(seq_req), 32'd0);
      chk("R2 reset done_flag", 32'(done_flag), 32'd0);

      rd(32'h0000_0100, 2'd2, "R3 first miss", 1, 1);
      chk("R9 flag set after burst", 32'(done_flag), 32'd1);
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      @(negedge clk);
      chk("R9 flag cleared by write-one", 32'(done_flag), 32'd0);

      rd(32'h0000_0108, 2'd2, "R5 inner hit", 1, 1);
      rd(32'h0000_011C, 2'd2, "R5 last word hit", 1, 1);
      rd(32'h0000_0120, 2'd2, "R5 one past range", 1, 1);
      rd(32'h0000_0121, 2'd0, "R6 byte lane 1", 1, 1);
      rd(32'h0000_0122, 2'd0, "R6 byte lane 2", 1, 1);
      rd(32'h0000_0123, 2'd0, "R6 byte lane 3", 1, 1);
      rd(32'h0000_0120, 2'd0, "R6 byte lane 0", 1, 1);
      rd(32'h0000_0126, 2'd1, "R6 upper half", 1, 1);
      rd(32'h0000_0124, 2'd1, "R6 lower half", 1, 1);
      rd(32'h0000_0128, 2'd3, "R6 size 3 as word", 1, 1);
      rd(32'h00F0_0124, 2'd2, "R1 alias hit", 1, 1);

      cfg_mask = 12'hFE0;
      rd(32'h0FFF_FFFC, 2'd2, "R1 21-bit window", 1, 1);
      cfg_mask = 12'hFC0;
      rd(32'h0FFF_FFE0, 2'd2, "R1 22-bit window", 1, 1);
      cfg_mask = 12'hF00;
      rd(32'h0FFF_FFF0, 2'd2, "R1 24-bit window", 1, 1);
      cfg_mask = 12'hE00;
      rd(32'h3FFF_FFF8, 2'd2, "R1 25-bit window high bits", 1, 1);
      cfg_mask = 12'hFFF;

      cfg_lim_en = 1; cfg_lim = 8'd2; cfg_cmd = 8'h6B; cfg_dummy = 5'd8;
      rd(32'h0000_2000, 2'd2, "R4 limit of three", 1, 1);
      rd(32'h0000_2008, 2'd2, "R4 limited range hit", 1, 1);
      rd(32'h0000_200C, 2'd2, "R4 beyond limited range", 1, 1);
      cfg_lim = 8'd20;
      rd(32'h0000_3000, 2'd2, "R4 limit above burst", 1, 1);
      cfg_lim = 8'd0;
      rd(32'h0000_4000, 2'd2, "R4 single word", 1, 1);
      rd(32'h0000_4004, 2'd2, "R4 single word next", 1, 1);
      cfg_lim_en = 0;

      cfg_rd_en = 0; m_valid = 0;
      rd(32'h0000_4000, 2'd2, "R8 read enable low", 1, 1);
      cfg_rd_en = 1; cfg_pf_en = 0;
      rd(32'h0000_4000, 2'd2, "R8 stream enable low", 1, 1);
      cfg_pf_en = 1;
      rd(32'h0000_4000, 2'd2, "R8 refetch after discard", 1, 1);

      rd(32'h0000_5000, 2'd2, "R10 first of pair", 0, 1);
      rd(32'h0000_5010, 2'd2, "R10 queued read", 1, 0);
      chk("R10 queued read waited", 32'(last_cyc > 1), 32'd1);

      finish_run();
   end

endmodule